// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees a hung I2C bus on request. It watches the SCL and SDA wires through a short synchronizer and reports their live levels together with a bus-busy flag, which is derived from START and STOP conditions seen on the wires. When a recovery command arrives, the block looks at the line levels and picks one of three actions:

- With SDA held low, it clocks SCL until the target lets go of SDA, up to a fixed pulse limit.
- With SCL low but SDA high, it generates a STOP condition.
- With both lines high, it does nothing.

Whichever action it takes, it sets a sticky recovery-done bit when it finishes.

The block drives the wires only through open-drain enables: a high enable pulls the wire low. The surrounding controller issues the command, reads the line status, and clears the done bit by writing a one to it. If SDA is still low after the last pulse, the block still reports completion. Software then sees a low SDA status bit and can treat the recovery as failed.

Top module: `i2c_bus_recover`

## Requirements
- R1: After reset both drive enables are low, the done bit (interrupt word bit 13) is 0, the busy flag (line word bit 16) is 0, and the SCL and SDA status bits read 1 while the wires are high.
- R2: Line word bit 18 follows the SCL wire and bit 17 follows the SDA wire, each through the synchronizer, within three clock cycles. All other bits of the line word read 0.
- R3: A command is accepted only when `cmdValid` is high and `cmdWord` bit 11 is set. A command word without bit 11 produces no drive and no done bit.
- R4: When both lines are high, an accepted command sets the done bit without driving either wire.
- R5: When SDA is low, an accepted command produces SCL pulses. Each pulse holds SCL low for HALF_CYCLES clocks and then releases it for HALF_CYCLES clocks. SDA is sampled at the end of each high phase, and the sequence ends on the first sample that finds SDA high.
- R6: At most MAX_PULSES (default 8) pulses are issued. If SDA is still low after the last pulse, the done bit is set anyway and line word bit 17 stays 0.
- R7: When SCL is low and SDA is high, the block generates a STOP in this order:
  1. It pulls SCL low.
  2. It then pulls SDA low while SCL is still held.
  3. It releases SCL.
  4. It releases SDA while SCL is high.

  In this mode SCL is pulled low exactly once.
- R8: The done bit is sticky. Writing with `intClrValid` and mask bit 13 set clears it. A mask without bit 13 leaves it unchanged. If a set and a clear fall in the same cycle, the set wins.
- R9: A command that arrives while a recovery is running is ignored. The running sequence neither restarts nor extends.
- R10: The busy flag is set when SDA falls while SCL is high (START) and cleared when SDA rises while SCL is high (STOP).
- R11: SDA is never driven during pulse mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Sampled SCL wire level |
| sdaIn | input | 1 | Sampled SDA wire level |
| cmdValid | input | 1 | Command write strobe |
| cmdWord | input | 32 | Command word; bit 11 requests recovery |
| intClrValid | input | 1 | Interrupt status write strobe (write-one-to-clear) |
| intClrMask | input | 32 | Bits to clear; bit 13 is the done bit |
| sclOe | output | 1 | Pull SCL low when high |
| sdaOe | output | 1 | Pull SDA low when high |
| lineStatus | output | 32 | Bit 18 SCL level, bit 17 SDA level, bit 16 bus busy |
| intStatus | output | 32 | Bit 13 recovery done |

## Verification
The two functions that can fall in the same cycle are the sequencer setting the done bit and software clearing it. The bench provokes the collision by holding a write-one-to-clear of bit 13 on every cycle of a whole pulse-mode recovery. The set must win, so the done bit is judged to be visible for exactly one cycle and low afterwards. A second overlap, a new command landing mid-sequence, is judged by counting the SCL pulses, which must not exceed the limit.

// File: rtl/i2crec_pkg.sv
package i2crec_pkg;
  localparam int REG_W           = 32;
  localparam int CMD_RECOVER_BIT = 11;
  localparam int LINE_SCL_BIT    = 18;
  localparam int LINE_SDA_BIT    = 17;
  localparam int LINE_BUSY_BIT   = 16;
  localparam int INT_DONE_BIT    = 13;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PLOW,
    ST_PHIGH,
    ST_SCLLOW,
    ST_SDALOW,
    ST_SCLHIGH,
    ST_SDAHIGH,
    ST_FINISH
  } recState_t;

  typedef struct packed {
    logic loadTimer;
    logic clrPulse;
    logic incPulse;
    logic driveScl;
    logic driveSda;
    logic setDone;
  } recStrobe_t;
endpackage

// File: rtl/i2crec_datapath.sv
module i2crec_datapath
  import i2crec_pkg::*;
#(
  parameter int HALF_CYCLES = 8,
  parameter int MAX_PULSES  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  recStrobe_t       strb,
  input  logic             intClrValid,
  input  logic [REG_W-1:0] intClrMask,
  output logic             timerDone,
  output logic             pulseLast,
  output logic             sclLvl,
  output logic             sdaLvl,
  output logic             sclOe,
  output logic             sdaOe,
  output logic [REG_W-1:0] lineStatus,
  output logic [REG_W-1:0] intStatus
);
  localparam int TW = (HALF_CYCLES > 2) ? $clog2(HALF_CYCLES) : 1;
  localparam int PW = $clog2(MAX_PULSES + 1);
  localparam logic [TW-1:0] TIMER_RELOAD = TW'(HALF_CYCLES - 1);
  localparam logic [PW-1:0] PULSE_LAST   = PW'(MAX_PULSES - 1);
  localparam logic [PW-1:0] PULSE_MAX    = PW'(MAX_PULSES);

  // Line synchronizers, reset to the idle (high) level.
  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe[0] <= 1'b1;
      sdaPipe[0] <= 1'b1;
    end else begin
      sclPipe[0] <= sclIn;
      sdaPipe[0] <= sdaIn;
    end
  end

  for (genvar g = 1; g < SYNC_STAGES; g++) begin : gSync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        sclPipe[g] <= 1'b1;
        sdaPipe[g] <= 1'b1;
      end else begin
        sclPipe[g] <= sclPipe[g-1];
        sdaPipe[g] <= sdaPipe[g-1];
      end
    end
  end

  assign sclLvl = sclPipe[SYNC_STAGES-1];
  assign sdaLvl = sdaPipe[SYNC_STAGES-1];

  // Phase timer
  logic [TW-1:0] timer;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                timer <= '0;
    else if (strb.loadTimer)  timer <= TIMER_RELOAD;
    else if (timer != '0)     timer <= timer - 1'b1;
  end
  assign timerDone = (timer == '0);

  // Pulse counter
  logic [PW-1:0] pulseCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               pulseCnt <= '0;
    else if (strb.clrPulse)  pulseCnt <= '0;
    else if (strb.incPulse)  pulseCnt <= pulseCnt + 1'b1;
  end
  assign pulseLast = (pulseCnt == PULSE_LAST);

  // Open-drain enables
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclOe <= 1'b0;
      sdaOe <= 1'b0;
    end else begin
      sclOe <= strb.driveScl;
      sdaOe <= strb.driveSda;
    end
  end

  // START / STOP detection for the busy flag
  logic prevScl, prevSda, busyFlag;
  logic startSeen, stopSeen;
  assign startSeen = sclLvl && prevScl && prevSda && !sdaLvl;
  assign stopSeen  = sclLvl && prevScl && !prevSda && sdaLvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevScl  <= 1'b1;
      prevSda  <= 1'b1;
      busyFlag <= 1'b0;
    end else begin
      prevScl <= sclLvl;
      prevSda <= sdaLvl;
      if (startSeen)     busyFlag <= 1'b1;
      else if (stopSeen) busyFlag <= 1'b0;
    end
  end

  // Sticky done bit; set beats a same-cycle clear
  logic doneBit, clrDone;
  assign clrDone = intClrValid && intClrMask[INT_DONE_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              doneBit <= 1'b0;
    else if (strb.setDone)  doneBit <= 1'b1;
    else if (clrDone)       doneBit <= 1'b0;
  end

  logic unusedMask;
  assign unusedMask = ^intClrMask;

  always_comb begin
    lineStatus = '0;
    lineStatus[LINE_SCL_BIT]  = sclLvl;
    lineStatus[LINE_SDA_BIT]  = sdaLvl;
    lineStatus[LINE_BUSY_BIT] = busyFlag;
    intStatus = '0;
    intStatus[INT_DONE_BIT] = doneBit;
  end

  assert_pulse_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    pulseCnt <= PULSE_MAX);
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.setDone |=> intStatus[INT_DONE_BIT]);
  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (intStatus[INT_DONE_BIT] && !clrDone) |=> intStatus[INT_DONE_BIT]);
  assert_busy_start_R10: assert property (@(posedge clk) disable iff (!rstN)
    startSeen |=> lineStatus[LINE_BUSY_BIT]);
endmodule

// File: rtl/i2crec_ctrl.sv
module i2crec_ctrl
  import i2crec_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       timerDone,
  input  logic       pulseLast,
  input  logic       sclLvl,
  input  logic       sdaLvl,
  output recStrobe_t strb,
  output logic       active,
  output logic       pulseMode
);
  recState_t state, stNext;

  always_comb begin
    stNext = state;
    strb   = '0;
    unique case (state)
      ST_IDLE: if (startReq) begin
        strb.clrPulse = 1'b1;
        if (!sdaLvl) begin
          stNext = ST_PLOW;
          strb.loadTimer = 1'b1;
        end else if (!sclLvl) begin
          stNext = ST_SCLLOW;
          strb.loadTimer = 1'b1;
        end else begin
          stNext = ST_FINISH;
        end
      end
      ST_PLOW: if (timerDone) begin
        stNext = ST_PHIGH;
        strb.loadTimer = 1'b1;
      end
      ST_PHIGH: if (timerDone) begin
        strb.incPulse = 1'b1;
        if (sdaLvl || pulseLast) begin
          stNext = ST_FINISH;
        end else begin
          stNext = ST_PLOW;
          strb.loadTimer = 1'b1;
        end
      end
      ST_SCLLOW: if (timerDone) begin
        stNext = ST_SDALOW;
        strb.loadTimer = 1'b1;
      end
      ST_SDALOW: if (timerDone) begin
        stNext = ST_SCLHIGH;
        strb.loadTimer = 1'b1;
      end
      ST_SCLHIGH: if (timerDone) begin
        stNext = ST_SDAHIGH;
        strb.loadTimer = 1'b1;
      end
      ST_SDAHIGH: if (timerDone) stNext = ST_FINISH;
      ST_FINISH: begin
        strb.setDone = 1'b1;
        stNext = ST_IDLE;
      end
      default: stNext = ST_IDLE;
    endcase
    strb.driveScl = (stNext == ST_PLOW) || (stNext == ST_SCLLOW) ||
                    (stNext == ST_SDALOW);
    strb.driveSda = (stNext == ST_SDALOW) || (stNext == ST_SCLHIGH);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stNext;
  end

  assign active    = (state != ST_IDLE);
  assign pulseMode = (state == ST_PLOW) || (state == ST_PHIGH);

  assert_finish_once_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FINISH) |=> (state == ST_IDLE));
  assert_ignore_cmd_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PLOW && !timerDone && startReq) |=> (state == ST_PLOW));
endmodule

// File: rtl/i2c_bus_recover.sv
module i2c_bus_recover
  import i2crec_pkg::*;
#(
  parameter int HALF_CYCLES = 8,
  parameter int MAX_PULSES  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  input  logic        cmdValid,
  input  logic [31:0] cmdWord,
  input  logic        intClrValid,
  input  logic [31:0] intClrMask,
  output logic        sclOe,
  output logic        sdaOe,
  output logic [31:0] lineStatus,
  output logic [31:0] intStatus
);
  recStrobe_t strb;
  logic timerDone, pulseLast, sclLvl, sdaLvl, active, pulseMode, startReq;
  logic unusedCmd;

  assign startReq  = cmdValid && cmdWord[CMD_RECOVER_BIT];
  assign unusedCmd = ^cmdWord;

  i2crec_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .timerDone(timerDone),
    .pulseLast(pulseLast), .sclLvl(sclLvl), .sdaLvl(sdaLvl),
    .strb(strb), .active(active), .pulseMode(pulseMode)
  );

  i2crec_datapath #(
    .HALF_CYCLES(HALF_CYCLES), .MAX_PULSES(MAX_PULSES), .SYNC_STAGES(SYNC_STAGES)
  ) uData (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .strb(strb),
    .intClrValid(intClrValid), .intClrMask(intClrMask),
    .timerDone(timerDone), .pulseLast(pulseLast), .sclLvl(sclLvl),
    .sdaLvl(sdaLvl), .sclOe(sclOe), .sdaOe(sdaOe),
    .lineStatus(lineStatus), .intStatus(intStatus)
  );

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> (!sclOe && !sdaOe));
  assert_pulse_no_sda_R11: assert property (@(posedge clk) disable iff (!rstN)
    pulseMode |-> !sdaOe);
  assert_stop_order_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> sclOe);
endmodule

// File: tb/tb_i2c_bus_recover.sv
module tb_i2c_bus_recover;
  logic clk = 0, rstN = 0;
  logic cmdValid = 0, intClrValid = 0;
  logic [31:0] cmdWord = 0, intClrMask = 0;
  logic sclOe, sdaOe;
  logic [31:0] lineStatus, intStatus;

  // Wire model
  logic tgtHoldSda = 0, tgtHoldScl = 0, mstSda = 0;
  int   releaseAt = 0, armSeq = 0, seenSeq = 0, riseCnt = 0;
  wire  sdaHeld = tgtHoldSda && (releaseAt == 0 || armSeq != seenSeq || riseCnt < releaseAt);
  wire  sclLine = !(sclOe || tgtHoldScl);
  wire  sdaLine = !(sdaOe || mstSda || sdaHeld);

  always @(posedge sclLine) begin
    if (armSeq != seenSeq) begin
      seenSeq = armSeq;
      riseCnt = 0;
    end
    riseCnt = riseCnt + 1;
  end

  i2c_bus_recover dut (
    .clk(clk), .rstN(rstN), .sclIn(sclLine), .sdaIn(sdaLine),
    .cmdValid(cmdValid), .cmdWord(cmdWord), .intClrValid(intClrValid),
    .intClrMask(intClrMask), .sclOe(sclOe), .sdaOe(sdaOe),
    .lineStatus(lineStatus), .intStatus(intStatus)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  int pulses, sdaRises, doneCycles, orderErr;

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Issues cmd at cycle 0 (and again at reissueAt), watches the wires.
  task automatic runRec(input logic [31:0] cmd, input int reissueAt,
                        input logic holdClr, input int maxCyc);
    logic pScl, pSda;
    pulses = 0; sdaRises = 0; doneCycles = 0; orderErr = 0;
    pScl = sclOe; pSda = sdaOe;
    for (int i = 0; i < maxCyc; i++) begin
      cmdValid    = (i == 0) || (i == reissueAt);
      cmdWord     = cmd;
      intClrValid = holdClr;
      intClrMask  = holdClr ? 32'h2000 : 32'h0;
      @(negedge clk);
      if (pScl && !sclOe) pulses++;
      if (!pSda && sdaOe) begin
        sdaRises++;
        if (!sclOe) orderErr++;
      end
      if (pSda && !sdaOe && !sclLine) orderErr++;
      if (sdaOe) tgtHoldScl = 0;
      pScl = sclOe; pSda = sdaOe;
      if (intStatus[13]) begin
        doneCycles++;
        if (!holdClr) break;
      end
    end
    cmdValid = 0; intClrValid = 0; intClrMask = 0;
  endtask

  task automatic clearDone;
    @(negedge clk); intClrValid = 1; intClrMask = 32'h2000;
    @(negedge clk); intClrValid = 0; intClrMask = 0;
  endtask

  localparam int NV = 6;
  localparam int REL   [NV] = '{1, 2, 3, 5, 8, 0};
  localparam int EXP_P [NV] = '{1, 2, 3, 5, 8, 8};
  localparam int EXP_SD[NV] = '{1, 1, 1, 1, 1, 0};

  initial begin
    idle(3); rstN = 1; idle(4);
    // R1 reset state
    check("R1 sclOe", {31'b0, sclOe}, 0);
    check("R1 sdaOe", {31'b0, sdaOe}, 0);
    check("R1 intStatus", intStatus, 0);
    check("R1 lineStatus", lineStatus, 32'h0006_0000);

    // R2 / R10: START then STOP via wire levels
    mstSda = 1; idle(4);
    check("R2 sda low seen", {31'b0, lineStatus[17]}, 0);
    check("R10 busy on START", {31'b0, lineStatus[16]}, 1);
    check("R2 other bits zero", lineStatus & 32'hFFF8_FFFF, 0);
    mstSda = 0; idle(4);
    check("R10 busy cleared on STOP", {31'b0, lineStatus[16]}, 0);
    tgtHoldScl = 1; idle(4);
    check("R2 scl low seen", {31'b0, lineStatus[18]}, 0);
    tgtHoldScl = 0; idle(4);

    // R3: command without the recover bit is ignored
    releaseAt = 0; armSeq++; tgtHoldSda = 1; idle(4);
    runRec(32'h0000_0020, -1, 0, 60);
    check("R3 no pulses", pulses, 0);
    check("R3 no done", {31'b0, intStatus[13]}, 0);
    tgtHoldSda = 0; idle(6);

    // R4: idle bus, done without drive
    runRec(32'h0000_0800, -1, 0, 40);
    check("R4 done set", {31'b0, intStatus[13]}, 1);
    check("R4 no scl pulses", pulses, 0);
    check("R4 no sda drive", sdaRises, 0);

    // R8: write-one-to-clear
    @(negedge clk); intClrValid = 1; intClrMask = 32'h0;
    @(negedge clk); intClrValid = 0;
    check("R8 zero mask keeps done", {31'b0, intStatus[13]}, 1);
    @(negedge clk); intClrValid = 1; intClrMask = 32'hFFFF_DFFF;
    @(negedge clk); intClrValid = 0; intClrMask = 0;
    check("R8 other bits keep done", {31'b0, intStatus[13]}, 1);
    clearDone;
    check("R8 bit13 clears done", {31'b0, intStatus[13]}, 0);

    // R5 / R6 / R11: pulse-mode vector table
    for (int v = 0; v < NV; v++) begin
      releaseAt = REL[v]; armSeq++; tgtHoldSda = 1; idle(5);
      runRec(32'h0000_0800, -1, 0, 400);
      check($sformatf("R5 R6 done vec%0d", v), {31'b0, intStatus[13]}, 1);
      check($sformatf("R5 R6 pulse count vec%0d", v), pulses, EXP_P[v]);
      check($sformatf("R11 no sda drive vec%0d", v), sdaRises, 0);
      idle(4);
      check($sformatf("R6 sda status vec%0d", v), {31'b0, lineStatus[17]}, EXP_SD[v]);
      clearDone;
      tgtHoldSda = 0; idle(6);
    end

    // R9: second command mid-sequence is ignored
    releaseAt = 0; armSeq++; tgtHoldSda = 1; idle(5);
    runRec(32'h0000_0800, 20, 0, 400);
    check("R9 pulse count not extended", pulses, 8);
    idle(60);
    check("R9 no further drive", {30'b0, sclOe, sdaOe}, 0);
    clearDone; tgtHoldSda = 0; idle(6);

    // R8 collision: continuous clear during a recovery, set wins
    releaseAt = 2; armSeq++; tgtHoldSda = 1; idle(5);
    runRec(32'h0000_0800, -1, 1, 300);
    check("R8 set wins over clear", doneCycles, 1);
    check("R8 cleared afterwards", {31'b0, intStatus[13]}, 0);
    tgtHoldSda = 0; idle(6);

    // R7: SCL stuck low, SDA high -> STOP
    mstSda = 1; idle(4); tgtHoldScl = 1; idle(2); mstSda = 0; idle(5);
    check("R7 precondition busy", lineStatus, 32'h0003_0000);
    runRec(32'h0000_0800, -1, 0, 200);
    check("R7 done", {31'b0, intStatus[13]}, 1);
    check("R7 single scl drive", pulses, 1);
    check("R7 single sda drive", sdaRises, 1);
    check("R7 stop ordering", orderErr, 0);
    idle(4);
    check("R7 R10 lines free, busy clear", lineStatus, 32'h0006_0000);
    clearDone;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule